// File: doc/BRIEF.md
# Next-PC and Stack Control Unit

This unit sits at the end of a single-cycle processor datapath. It looks at the decoded instruction class and the values the earlier stages have produced, and from them it picks the address of the next instruction. It also works out the stack-pointer adjustment, the data-memory address, and the memory read and write strobes for calls, returns, pushes and pops. It holds the two pieces of architectural state that it alone updates: the program counter and the three-bit condition-code register.

The stack grows downward in 8-byte steps. A push or call first moves the pointer down and then stores at the new address. A pop or return reads at the old address and moves the pointer up. The surrounding datapath writes the adjusted pointer, `val_e`, back to the register file. A `run_ok` input carries the processor status. While it is low, the PC is frozen and no memory write or flag load is allowed, so the machine stops after a halt or a fault.

Top module: `pc_stack_ctl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after release, `pc` equals parameter `RESET_PC` (default 0) and `cc` equals 3'b100 (bit order {zero, sign, overflow}).
- R2: `next_pc` is `val_c` for a call (`icode`=8) and for a jump (`icode`=7) with `cnd`=1. It is `val_m` for a return (`icode`=9). In every other case, including a jump with `cnd`=0 and unused codes, it is `val_p`.
- R3: With `run_ok`=1, `pc` takes the value of `next_pc` at every rising edge. With `run_ok`=0, `pc` keeps its value.
- R4: `val_e` is `val_b`−8 for push (`icode`=10) and call. It is `val_b`+8 for pop (`icode`=11) and return. For any other code it is `val_b` unchanged.
- R5: `mem_addr` is the decremented pointer (`val_b`−8) for push and call, and `val_a` for pop and return. For other codes it is zero.
- R6: `mem_we` is 1 only when `run_ok`=1 and the code is register-to-memory store (`icode`=4), push or call.
- R7: `mem_wdata` is `val_p` for a call and `val_a` for every other code.
- R8: `mem_re` is 1 exactly for memory-to-register load (`icode`=5), pop and return.
- R9: `cc_load` is 1 exactly when `icode`=6 (integer ALU operation) and `run_ok`=1. At that rising edge `cc` takes `cc_in`. At every other edge `cc` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_ok | input | 1 | Processor status is normal |
| icode | input | 4 | Instruction class code |
| ifun | input | 4 | Instruction function code (unused here) |
| cnd | input | 1 | Branch condition outcome |
| val_a | input | W | Operand A (old stack pointer for pop/ret, store data) |
| val_b | input | W | Operand B (current stack pointer) |
| val_c | input | W | Instruction constant |
| val_p | input | W | Sequential next address |
| val_m | input | W | Value read from data memory |
| cc_in | input | 3 | Flags computed by the ALU |
| next_pc | output | W | Selected next instruction address |
| pc | output | W | Program counter register |
| val_e | output | W | Adjusted stack pointer |
| mem_addr | output | W | Data-memory address |
| mem_wdata | output | W | Data-memory write data |
| mem_we | output | 1 | Data-memory write enable |
| mem_re | output | 1 | Data-memory read enable |
| cc_load | output | 1 | Condition-code load strobe |
| cc | output | 3 | Condition-code register |

## Verification
A call redirects the PC and writes the return address to memory in the same cycle. In that cycle `next_pc` must carry `val_c` while `mem_wdata` carries `val_p` at address `val_b`−8. The bench drives call cycles with random, unrelated values on every operand, so any swap of those sources shows up. It also drives call, store and ALU cycles with `run_ok` low. In those cycles a correct unit shows a frozen PC and unchanged flags, with no write strobe. A reference model in the bench checks this on every clock.

// File: rtl/pc_stack_ctl.sv
module pc_stack_ctl #(
  parameter int W = 64,
  parameter int STEP = 8,
  parameter logic [W-1:0] RESET_PC = '0,
  parameter logic [2:0] CC_RESET = 3'b100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_ok,
  input  logic [3:0]   icode,
  input  logic [3:0]   ifun,
  input  logic         cnd,
  input  logic [W-1:0] val_a,
  input  logic [W-1:0] val_b,
  input  logic [W-1:0] val_c,
  input  logic [W-1:0] val_p,
  input  logic [W-1:0] val_m,
  input  logic [2:0]   cc_in,
  output logic [W-1:0] next_pc,
  output logic [W-1:0] pc,
  output logic [W-1:0] val_e,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         mem_we,
  output logic         mem_re,
  output logic         cc_load,
  output logic [2:0]   cc
);
  localparam logic [3:0] C_STORE = 4'd4, C_LOAD = 4'd5, C_ALU = 4'd6, C_JUMP = 4'd7,
                         C_CALL = 4'd8, C_RET = 4'd9, C_PUSH = 4'd10, C_POP = 4'd11;
  localparam logic [W-1:0] STEP_W = W'(STEP);

  logic is_call, is_ret, is_push, is_pop, goes_down, goes_up;
  logic unused_fun;

  assign unused_fun = ^ifun;
  assign is_call   = (icode == C_CALL);
  assign is_ret    = (icode == C_RET);
  assign is_push   = (icode == C_PUSH);
  assign is_pop    = (icode == C_POP);
  assign goes_down = is_call | is_push;
  assign goes_up   = is_ret | is_pop;

  always_comb begin
    if (is_call)                        next_pc = val_c;
    else if (icode == C_JUMP && cnd)    next_pc = val_c;
    else if (is_ret)                    next_pc = val_m;
    else                                next_pc = val_p;
  end

  assign val_e     = goes_down ? val_b - STEP_W : goes_up ? val_b + STEP_W : val_b;
  assign mem_addr  = goes_down ? val_e : goes_up ? val_a : '0;
  assign mem_wdata = is_call ? val_p : val_a;
  assign mem_we    = run_ok & (goes_down | icode == C_STORE);
  assign mem_re    = goes_up | icode == C_LOAD;
  assign cc_load   = run_ok & (icode == C_ALU);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= RESET_PC;
      cc <= CC_RESET;
    end else begin
      if (run_ok)  pc <= next_pc;
      if (cc_load) cc <= cc_in;
    end
  end
endmodule

module pc_stack_ctl_chk #(parameter int W = 64) (
  input logic         clk,
  input logic         rst_n,
  input logic         run_ok,
  input logic [3:0]   icode,
  input logic [W-1:0] val_b,
  input logic [W-1:0] val_p,
  input logic [W-1:0] next_pc,
  input logic [W-1:0] pc,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] mem_wdata,
  input logic         mem_we,
  input logic [2:0]   cc,
  input logic [2:0]   cc_in
);
  // R3
  pc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_ok |=> pc == $past(next_pc));
  // R3
  pc_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_ok |=> $stable(pc));
  // R9
  cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_ok && icode == 4'd6) |=> $stable(cc));
  // R9
  cc_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_ok && icode == 4'd6) |=> cc == $past(cc_in));
  // R6
  we_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (run_ok && (icode == 4'd4 || icode == 4'd8 || icode == 4'd10)));
  // R7
  call_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (icode == 4'd8) |-> (mem_wdata == val_p && mem_addr == val_b - W'(8)));
endmodule

bind pc_stack_ctl pc_stack_ctl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_ok(run_ok), .icode(icode), .val_b(val_b),
  .val_p(val_p), .next_pc(next_pc), .pc(pc), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_we(mem_we), .cc(cc), .cc_in(cc_in));

// File: tb/pc_stack_ctl_tb.sv
`timescale 1ns/1ps
module pc_stack_ctl_tb;
  localparam int W = 64;
  logic clk = 0, rst_n = 0, run_ok = 0, cnd = 0;
  logic [3:0] icode = 0, ifun = 0;
  logic [W-1:0] val_a = 0, val_b = 0, val_c = 0, val_p = 0, val_m = 0;
  logic [2:0] cc_in = 0;
  logic [W-1:0] next_pc, pc, val_e, mem_addr, mem_wdata;
  logic mem_we, mem_re, cc_load;
  logic [2:0] cc;
  int checks = 0, errors = 0;
  logic [W-1:0] m_pc;
  logic [2:0] m_cc;
  logic done = 0;

  always #2 clk = ~clk;

  pc_stack_ctl u_dut (.*);

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_comb();
    logic [W-1:0] e_npc, e_e, e_addr, e_wd;
    logic e_we, e_re, e_ld;
    e_npc = val_p; e_e = val_b; e_addr = 0; e_wd = val_a; e_we = 0; e_re = 0;
    case (icode)
      4'd4: e_we = 1;
      4'd5: e_re = 1;
      4'd7: if (cnd) e_npc = val_c;
      4'd8: begin e_npc = val_c; e_e = val_b - 8; e_addr = val_b - 8; e_wd = val_p; e_we = 1; end
      4'd9: begin e_npc = val_m; e_e = val_b + 8; e_addr = val_a; e_re = 1; end
      4'd10: begin e_e = val_b - 8; e_addr = val_b - 8; e_we = 1; end
      4'd11: begin e_e = val_b + 8; e_addr = val_a; e_re = 1; end
      default: ;
    endcase
    e_we = e_we & run_ok;
    e_ld = run_ok && icode == 4'd6;
    chk("R2", "next_pc", next_pc, e_npc);
    chk("R4", "val_e", val_e, e_e);
    chk("R5", "mem_addr", mem_addr, e_addr);
    chk("R7", "mem_wdata", mem_wdata, e_wd);
    chk("R6", "mem_we", W'(mem_we), W'(e_we));
    chk("R8", "mem_re", W'(mem_re), W'(e_re));
    chk("R9", "cc_load", W'(cc_load), W'(e_ld));
    if (run_ok) m_pc = e_npc;
    if (e_ld) m_cc = cc_in;
  endtask

  task automatic cycle(logic [3:0] ic, logic c, logic ok);
    @(negedge clk);
    icode = ic; cnd = c; run_ok = ok; ifun = 4'($urandom);
    val_a = {$urandom, $urandom}; val_b = {$urandom, $urandom};
    val_c = {$urandom, $urandom}; val_p = {$urandom, $urandom};
    val_m = {$urandom, $urandom}; cc_in = 3'($urandom);
    #1 check_comb();
    @(posedge clk); #1;
    chk("R3", "pc", pc, m_pc);
    chk("R9", "cc", W'(cc), W'(m_cc));
  endtask

  initial begin
    m_pc = 0; m_cc = 3'b100;
    #5;
    // R1 reset state
    chk("R1", "pc reset", pc, 0);
    chk("R1", "cc reset", W'(cc), W'(3'b100));
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk("R1", "pc after release", pc, 0);
    chk("R1", "cc after release", W'(cc), W'(3'b100));
    // directed: every class, jump both ways, halted cycles
    for (int i = 0; i < 16; i++) cycle(4'(i), 1'b0, 1'b1);
    cycle(4'd7, 1'b1, 1'b1);
    cycle(4'd7, 1'b0, 1'b1);
    cycle(4'd8, 1'b0, 1'b0);
    cycle(4'd4, 1'b0, 1'b0);
    cycle(4'd6, 1'b0, 1'b0);
    cycle(4'd6, 1'b0, 1'b1);
    cycle(4'd9, 1'b1, 1'b0);
    for (int i = 0; i < 600; i++)
      cycle(4'($urandom), 1'($urandom), ($urandom % 5) != 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule